// File: doc/BRIEF.md
# Byte Serial Slave with Write-Collision Flag

This block is the receive and transmit end of a four-wire serial link. An external master drives the serial clock, the master-to-slave data line and an active-low select. The block answers on the slave-to-master data line, which carries a separate output enable. Each transfer moves one byte in each direction, most significant bit first. Two mode inputs choose one of four clocking formats. The clock-polarity input sets only the idle level of the clock. The clock-phase input decides which clock edge samples incoming data and which edge moves outgoing data.

A local processor sees a small parallel port. It can write the next byte to send, read the last byte received, and read two flags: byte-complete and write-collision. The serial pins are oversampled by the faster system clock through two-flop synchronisers, and clock edges are found from the synchronised samples.

In phase mode 0 every byte needs its own fall of the select line. A local write that arrives while the select line is low is refused and raises the collision flag. In phase mode 1 the select line may stay low over many bytes, and every eight clock cycles form one byte.

Top module: `spi_byte_slave`

## Requirements
- R1: Right after reset, `done_flag`, `coll_flag` and `miso_oe` are 0 and `rd_data` is 0x00.
- R2: In all four settings of `cpol`/`cpha`, the byte written on `wr_data` is sent MSB first, and the byte on `mosi_pin` is received MSB first. `cpol`=0 means the clock idles low; `cpol`=1 means it idles high.
- R3: With `cpha`=0, the slave samples `mosi_pin` on the leading edge (the edge away from the idle level) and updates `miso_out` on the trailing edge. The MSB is on `miso_out` within three system clocks after `ss_n_pin` falls, before the first clock edge.
- R4: With `cpha`=1, the slave updates `miso_out` on the leading edge and samples `mosi_pin` on the trailing edge.
- R5: With `cpha`=0, once eight bits have been sampled, further clock edges are ignored until `ss_n_pin` goes high. They cause no new byte-complete and no change to `rd_data`.
- R6: With `cpha`=1, `ss_n_pin` may stay low. Every eight sampling edges complete one byte, and a byte written between bytes is sent as the next byte.
- R7: A high level on `ss_n_pin` abandons a partial byte, and the next low starts counting at bit 7.
- R8: `done_flag` rises on the eighth sampling edge of a byte. `rd_data` takes the received byte at that moment and changes at no other time.
- R9: `done_flag` is cleared only by a `stat_rd` pulse while it is set, followed by a `rd_en` pulse. A `rd_en` pulse on its own leaves it set.
- R10: With `cpha`=0, a `wr_en` pulse while the synchronised select is low sets `coll_flag` and leaves the byte to be sent unchanged.
- R11: `coll_flag` stays set until a `coll_clr` pulse. Writes with `cpha`=1 never set it.
- R12: `miso_oe` is 0 whenever the synchronised select is high and 1 whenever it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Clock idle level (0 low, 1 high) |
| cpha | input | 1 | Phase mode select |
| sck_pin | input | 1 | Serial clock from master |
| mosi_pin | input | 1 | Serial data from master |
| ss_n_pin | input | 1 | Active-low select from master |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for miso_out |
| wr_en | input | 1 | Write strobe for the byte to send |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Last received byte |
| stat_rd | input | 1 | Status read strobe |
| done_flag | output | 1 | Byte-complete flag |
| coll_flag | output | 1 | Write-collision flag |
| coll_clr | input | 1 | Clears the collision flag |

## Verification
The assertions check the bit counter's range and its reset while the select is high, the hold of the received byte once a phase-0 frame is full, and the causes of every rise and fall of the two flags. They also check that a refused write leaves the transmit byte alone and that the received byte moves only on a completed transfer. Only the bench's scenarios can show the actual bit order and edge choice in each of the four modes. The same goes for the early MSB in phase mode 0, back-to-back bytes under a held select, recovery from an aborted byte, and the two-step flag clear.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  // Edge events derived from the synchronised serial clock
  typedef struct packed {
    logic lead;   // transition away from the idle level
    logic trail;  // transition back to the idle level
  } sck_evt_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          ss_n_s,
  input  logic [DW-1:0] tx_hold,
  output logic          miso_bit,
  output logic          byte_done,
  output logic [DW-1:0] rx_next
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  logic          sck_prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          miso_q, miso_d;
  sck_evt_t      evt;
  logic          sample_e, shift_e;

  always_comb begin
    evt.lead  = !ss_n_s && (sck_s != sck_prev_q) && (sck_s != cpol);
    evt.trail = !ss_n_s && (sck_s != sck_prev_q) && (sck_s == cpol);
    sample_e  = cpha ? evt.trail : evt.lead;
    shift_e   = cpha ? evt.lead  : evt.trail;
  end

  always_comb begin
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    miso_d    = miso_q;
    byte_done = 1'b0;
    if (ss_n_s) begin
      cnt_d = '0;
      tx_d  = tx_hold;
    end else begin
      if (sample_e && (cnt_q != CNT_FULL)) begin
        rx_d = {rx_q[DW-2:0], mosi_s};
        if (cnt_q == CNT_LAST) begin
          byte_done = 1'b1;
          cnt_d     = cpha ? '0 : CNT_FULL;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (shift_e) begin
        if (cpha) begin
          if (cnt_q == '0) begin
            miso_d = tx_hold[DW-1];
            tx_d   = {tx_hold[DW-2:0], 1'b0};
          end else begin
            miso_d = tx_q[DW-1];
            tx_d   = {tx_q[DW-2:0], 1'b0};
          end
        end else if (cnt_q != CNT_FULL) begin
          tx_d = {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      miso_q     <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      cnt_q      <= cnt_d;
      rx_q       <= rx_d;
      tx_q       <= tx_d;
      miso_q     <= miso_d;
    end
  end

  assign rx_next  = rx_d;
  assign miso_bit = cpha ? miso_q : tx_q[DW-1];

  // R5: counter never passes a full byte
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R7: a high select empties the bit counter
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_s |=> (cnt_q == '0));
  // R5: a full phase-0 frame freezes the receive shifter
  p_frame_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpha && !ss_n_s && cnt_q == CNT_FULL) |=> $stable(rx_q));
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpha,
  input  logic          ss_n_s,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  input  logic          rd_en,
  input  logic          coll_clr,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_next,
  output logic [DW-1:0] tx_hold,
  output logic [DW-1:0] rx_buf,
  output logic          done_flag,
  output logic          coll_flag
);
  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d;
  logic          done_q, done_d, armed_q, armed_d, coll_q, coll_d;
  logic          collide;

  always_comb begin
    collide = wr_en && !cpha && !ss_n_s;
    tx_d    = (wr_en && !collide) ? wr_data : tx_q;
    rx_d    = byte_done ? rx_next : rx_q;
    armed_d = armed_q;
    done_d  = done_q;
    if (stat_rd && done_q) armed_d = 1'b1;
    if (rd_en && armed_q) begin
      done_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (byte_done) done_d = 1'b1;
    coll_d = coll_q;
    if (coll_clr) coll_d = 1'b0;
    if (collide)  coll_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      done_q  <= done_d;
      armed_q <= armed_d;
      coll_q  <= coll_d;
    end
  end

  assign tx_hold   = tx_q;
  assign rx_buf    = rx_q;
  assign done_flag = done_q;
  assign coll_flag = coll_q;

  p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(byte_done));
  p_rxbuf_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_q) |-> $past(byte_done));
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(rd_en && armed_q));
  p_coll_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> $past(wr_en && !cpha && !ss_n_s));
  p_hold_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cpha && !ss_n_s) |=> $stable(tx_q));
  p_coll_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coll_q) |-> $past(coll_clr));
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck_pin,
  input  logic          mosi_pin,
  input  logic          ss_n_pin,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          stat_rd,
  output logic          done_flag,
  output logic          coll_flag,
  input  logic          coll_clr
);
  logic [2:0]    pins_s;
  logic          sck_s, mosi_s, ss_n_s;
  logic [DW-1:0] tx_hold, rx_next;
  logic          byte_done;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_pin, mosi_pin, ss_n_pin}), .q(pins_s)
  );
  assign sck_s  = pins_s[2];
  assign mosi_s = pins_s[1];
  assign ss_n_s = pins_s[0];

  spi_shift_core #(.DW(DW)) i_core (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
    .sck_s(sck_s), .mosi_s(mosi_s), .ss_n_s(ss_n_s), .tx_hold(tx_hold),
    .miso_bit(miso_out), .byte_done(byte_done), .rx_next(rx_next)
  );

  spi_host_regs #(.DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_n), .cpha(cpha), .ss_n_s(ss_n_s),
    .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd), .rd_en(rd_en),
    .coll_clr(coll_clr), .byte_done(byte_done), .rx_next(rx_next),
    .tx_hold(tx_hold), .rx_buf(rd_data), .done_flag(done_flag),
    .coll_flag(coll_flag)
  );

  assign miso_oe = !ss_n_s;
endmodule

// File: tb/test_spi_byte_slave.sv
module test_spi_byte_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;   // system clocks per serial half period
  localparam int NVEC = 8;
  // {cpol, cpha, byte slave sends, byte master sends}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C}, {1'b1, 1'b0, 8'h01, 8'h80},
    {1'b0, 1'b1, 8'hC3, 8'h5A}, {1'b1, 1'b1, 8'h7E, 8'h81},
    {1'b0, 1'b0, 8'hFF, 8'h00}, {1'b1, 1'b1, 8'h00, 8'hFF},
    {1'b0, 1'b1, 8'h96, 8'h69}, {1'b1, 1'b0, 8'h4D, 8'hB2}
  };

  logic clk = 0, rst_n = 0;
  logic cpol = 0, cpha = 0, sck = 0, mosi = 0, ss_n = 1;
  logic wr_en = 0, rd_en = 0, stat_rd = 0, coll_clr = 0;
  logic [7:0] wr_data = 0;
  logic miso_out, miso_oe, done_flag, coll_flag;
  logic [7:0] rd_data, got;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_slave i_spi_byte_slave (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sck_pin(sck),
    .mosi_pin(mosi), .ss_n_pin(ss_n), .miso_out(miso_out), .miso_oe(miso_oe),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .stat_rd(stat_rd), .done_flag(done_flag), .coll_flag(coll_flag),
    .coll_clr(coll_clr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    wr_data = b; wr_en = 1; tick(1); wr_en = 0; tick(1);
  endtask

  task automatic clear_done();
    stat_rd = 1; tick(1); stat_rd = 0; rd_en = 1; tick(1); rd_en = 0; tick(1);
  endtask

  task automatic set_mode(input logic p, input logic h);
    cpol = p; cpha = h; sck = p; tick(4);
  endtask

  // Master model: n clock cycles, sends mo, returns bits seen on miso
  task automatic xfer(input logic [7:0] mo, input int n, output logic [7:0] mi);
    mi = '0;
    if (ss_n) begin ss_n = 0; end
    if (!cpha) mosi = mo[7];
    tick(HALF);
    for (int i = 7; i > 7 - n; i--) begin
      sck = ~cpol;
      if (cpha) mosi = mo[i]; else mi[i] = miso_out;
      tick(HALF);
      sck = cpol;
      if (cpha) mi[i] = miso_out; else if (i > 0) mosi = mo[i-1];
      tick(HALF);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 done", {7'd0, done_flag}, 8'h00);
    chk("R1 coll", {7'd0, coll_flag}, 8'h00);
    chk("R1 oe", {7'd0, miso_oe}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    rst_n = 1; tick(2);

    // R2 R3 R4 R8 R9: all four modes from the vector table
    for (int v = 0; v < NVEC; v++) begin
      set_mode(VEC[v][17], VEC[v][16]);
      write_byte(VEC[v][15:8]);
      xfer(VEC[v][7:0], 8, got);
      chk(VEC[v][16] ? "R2 R4 miso byte" : "R2 R3 miso byte", got, VEC[v][15:8]);
      chk("R2 rd_data", rd_data, VEC[v][7:0]);
      chk("R8 done set", {7'd0, done_flag}, 8'h01);
      ss_n = 1; tick(4);
      rd_en = 1; tick(1); rd_en = 0; tick(1);
      chk("R9 read alone keeps done", {7'd0, done_flag}, 8'h01);
      clear_done();
      chk("R9 done cleared", {7'd0, done_flag}, 8'h00);
      chk("R8 rd_data stable", rd_data, VEC[v][7:0]);
    end

    // R5: phase 0, select held after a full byte
    set_mode(0, 0);
    write_byte(8'h33);
    xfer(8'h5A, 8, got);
    clear_done();
    xfer(8'hFF, 8, got);
    chk("R5 no second done", {7'd0, done_flag}, 8'h00);
    chk("R5 rd_data kept", rd_data, 8'h5A);
    ss_n = 1; tick(4);

    // R6 R11: phase 1, select held across two bytes with a write between
    set_mode(1, 1);
    write_byte(8'h3C);
    xfer(8'h81, 8, got);
    chk("R6 first byte out", got, 8'h3C);
    chk("R6 first byte in", rd_data, 8'h81);
    clear_done();
    write_byte(8'hC3);
    chk("R11 no collision in phase 1", {7'd0, coll_flag}, 8'h00);
    xfer(8'h7E, 8, got);
    chk("R6 second byte out", got, 8'hC3);
    chk("R6 second byte in", rd_data, 8'h7E);
    chk("R6 second done", {7'd0, done_flag}, 8'h01);
    ss_n = 1; tick(4);
    clear_done();

    // R7 R12: abort a partial byte, then a full one
    set_mode(0, 1);
    write_byte(8'h69);
    xfer(8'hF0, 3, got);
    chk("R12 oe while selected", {7'd0, miso_oe}, 8'h01);
    ss_n = 1; tick(4);
    chk("R12 oe after release", {7'd0, miso_oe}, 8'h00);
    chk("R7 no done on abort", {7'd0, done_flag}, 8'h00);
    xfer(8'h96, 8, got);
    chk("R7 byte after abort in", rd_data, 8'h96);
    chk("R7 byte after abort out", got, 8'h69);
    ss_n = 1; tick(4);
    clear_done();

    // R10 R11: collision in phase 0
    set_mode(0, 0);
    write_byte(8'h11);
    ss_n = 0; tick(4);
    write_byte(8'hEE);
    chk("R10 collision set", {7'd0, coll_flag}, 8'h01);
    xfer(8'h22, 8, got);
    chk("R10 byte unchanged", got, 8'h11);
    chk("R11 collision held", {7'd0, coll_flag}, 8'h01);
    ss_n = 1; tick(4);
    coll_clr = 1; tick(1); coll_clr = 0; tick(1);
    chk("R11 collision cleared", {7'd0, coll_flag}, 8'h00);

    finished = 1;
    report();
  end
endmodule